// File: doc/BRIEF.md
# Capture/Reload Timer with Up/Down Counting

This block is a 16-bit timer/counter for a microcontroller subsystem. It advances either on every machine-cycle tick (timer mode) or on falling edges of an external count pin, sampled once per tick (counter mode). A second external pin, the event pin, can copy the running count into a 16-bit capture/reload register or force a reload from it. In auto-reload mode with down counting enabled, the same pin instead selects the count direction.

A baud mode drives a neighbouring serial port. In this mode every overflow reloads the counter and produces a one-clock pulse on `baud_tick_o`, and the overflow flag stays clear. Software uses a byte-wide register port with combinational read-back to reach the control byte, the mode byte, the count and the reload value. Two sticky flags, overflow and external event, drive an interrupt request. All pins are plain level controls. No stream interface is involved, so there is no back-pressure.

Top module: `cr_timer`

## Requirements
- R1: Register addresses are 0 = control, 1 = mode (bit 0 = down enable), 2/3 = count low/high byte, 4/5 = reload low/high byte. After reset all six read 0, and `irq_o` and `baud_tick_o` are 0.
- R2: Control bits are bit 0 run, bit 1 external count source, bit 2 capture select, bit 3 event enable, bit 4 transmit-clock select, bit 5 receive-clock select, bit 6 event flag, bit 7 overflow flag. With run=1 and bit 1=0, the count rises by one on each clock edge where `tick_i` is 1, and holds on edges where `tick_i` is 0.
- R3: With run=0 the count holds, except for register writes and event-pin reloads.
- R4: With bit 1=1, `cnt_pin_i` is sampled only on tick edges. The count rises by one on a tick where the previous sample was 1 and the current level is 0. Toggles between ticks have no effect.
- R5: In capture mode (bit 2=1, bits 4 and 5 at 0) with the event enable set, a falling edge of `ext_pin_i` (sampled on ticks) copies the count into the reload register and sets bit 6. This happens whether or not run is set.
- R6: In capture mode, an overflow from FFFFh wraps the count to 0 and sets bit 7, and the reload register is unchanged. `irq_o` is 1 while an enabled flag is set.
- R7: In auto-reload mode (bit 2=0), counting up from FFFFh loads the reload value and sets bit 7.
- R8: In auto-reload mode with down enable=0 and the event enable set, an event-pin falling edge loads the count from the reload register and sets bit 6.
- R9: Flags set by hardware stay set until software writes 0 to them at address 0. A hardware set on the same edge as a write wins.
- R10: In auto-reload mode with down enable=1, the `ext_pin_i` level picks the direction (1 up, 0 down). Counting down while the count equals the reload value wraps it to FFFFh and sets bit 7.
- R11: In down mode, event-pin edges neither reload nor set bit 6, and bit 6 does not raise `irq_o`.
- R12: With bit 4 or bit 5 set (baud mode), capture select is ignored. Overflow reloads the count and never sets bit 7. `baud_tick_o` is 1 for exactly the clock after the overflow edge, while the count already shows the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle tick, one clock wide |
| cnt_pin_i | input | 1 | External count pin |
| ext_pin_i | input | 1 | Event pin: capture/reload trigger or direction |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, combinational from `addr_i` |
| baud_tick_o | output | 1 | One-clock pulse on each baud-mode overflow |
| irq_o | output | 1 | Interrupt request from the enabled flags |

## Verification
The bench targets the down-count wrap point. A design that compared the count against zero instead of the reload value would miss the FFFFh wrap, or place it on the wrong tick. It feeds event-pin falling edges in down mode, where a careless design would reload or flag them, and baud-mode overflows, where a design that forgot to gate the flag would set bit 7 or leave the capture select active. It also toggles the count pin between ticks: an edge detector that ran every clock instead of every tick would count those toggles.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_RLD_LO = 3'd4,
    A_RLD_HI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic ovf;
    logic evt;
    logic rx_clk;
    logic tx_clk;
    logic evt_en;
    logic cap_sel;
    logic src_ext;
    logic run;
  } ctrl_t;

  typedef enum logic [1:0] {
    M_CAPTURE = 2'd0,
    M_RELOAD  = 2'd1,
    M_BAUD    = 2'd2
  } mode_e;
endpackage

// File: rtl/cr_timer_edge.sv
module cr_timer_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] last_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_q[i] <= 1'b0;
      else if (tick_i) last_q[i] <= pin_i[i];
    end
    assign fall_o[i] = tick_i & last_q[i] & ~pin_i[i];
  end
endmodule

// File: rtl/cr_timer_core.sv
module cr_timer_core
  import cr_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NB = CNT_W / DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             down_i,
  input  mode_e            mode_i,
  input  logic             evt_reload_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic [NB-1:0]    wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic at_top, at_floor;

  assign at_top   = (cnt_q == {CNT_W{1'b1}});
  assign at_floor = (cnt_q == rld_i);
  assign wrap_o   = step_i & (down_i ? at_floor : at_top);

  always_comb begin
    nxt = cnt_q;
    if (evt_reload_i) begin
      nxt = rld_i;
    end else if (step_i) begin
      if (down_i)      nxt = at_floor ? {CNT_W{1'b1}} : cnt_q - 1'b1;
      else if (at_top) nxt = (mode_i == M_CAPTURE) ? '0 : rld_i;
      else             nxt = cnt_q + 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q[b*DW +: DW] <= '0;
      else if (wr_i[b]) cnt_q[b*DW +: DW] <= wdata_i;
      else            cnt_q[b*DW +: DW] <= nxt[b*DW +: DW];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cr_timer_regs.sv
module cr_timer_regs
  import cr_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NB = CNT_W / DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl_i,
  input  logic             wr_mode_i,
  input  logic [NB-1:0]    wr_rld_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             set_ovf_i,
  input  logic             set_evt_i,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ctrl_t            ctrl_o,
  output logic             down_en_o,
  output logic [CNT_W-1:0] rld_o
);
  ctrl_t ctrl_q;
  logic down_q;
  logic [CNT_W-1:0] rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      down_q <= 1'b0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i);
      if (set_ovf_i) ctrl_q.ovf <= 1'b1;
      if (set_evt_i) ctrl_q.evt <= 1'b1;
      if (wr_mode_i) down_q <= wdata_i[0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_rld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rld_q[b*DW +: DW] <= '0;
      else if (wr_rld_i[b]) rld_q[b*DW +: DW] <= wdata_i;
      else if (capture_i)  rld_q[b*DW +: DW] <= cnt_i[b*DW +: DW];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign down_en_o = down_q;
  assign rld_o     = rld_q;
endmodule

// File: rtl/cr_timer.sv
module cr_timer
  import cr_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cnt_pin_i,
  input  logic          ext_pin_i,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          baud_tick_o,
  output logic          irq_o
);
  localparam int NB = CNT_W / DW;

  ctrl_t            ctrl_q;
  logic             down_en_q;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [1:0]       fall;
  logic             cnt_fall, ext_fall;
  mode_e            mode;
  logic             down_mode, step, wrap, baud_q;
  logic             capture, evt_reload, set_evt, set_ovf;
  logic [NB-1:0]    wr_cnt, wr_rld;

  cr_timer_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .pin_i({ext_pin_i, cnt_pin_i}), .fall_o(fall)
  );
  assign cnt_fall = fall[0];
  assign ext_fall = fall[1];

  always_comb begin
    if (ctrl_q.rx_clk | ctrl_q.tx_clk) mode = M_BAUD;
    else if (ctrl_q.cap_sel)           mode = M_CAPTURE;
    else                               mode = M_RELOAD;
  end

  assign down_mode  = (mode == M_RELOAD) & down_en_q;
  assign step       = tick_i & ctrl_q.run & (ctrl_q.src_ext ? cnt_fall : 1'b1);
  assign capture    = ext_fall & ctrl_q.evt_en & (mode == M_CAPTURE);
  assign evt_reload = ext_fall & ctrl_q.evt_en & (mode == M_RELOAD) & ~down_en_q;
  assign set_evt    = ext_fall & ctrl_q.evt_en & ~down_mode;
  assign set_ovf    = wrap & (mode != M_BAUD);

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign wr_cnt[b] = wr_en_i & (addr_i == 3'(A_CNT_LO) + 3'(b));
    assign wr_rld[b] = wr_en_i & (addr_i == 3'(A_RLD_LO) + 3'(b));
  end

  cr_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step_i(step),
    .down_i(down_mode & ~ext_pin_i), .mode_i(mode),
    .evt_reload_i(evt_reload), .rld_i(rld_q),
    .wr_i(wr_cnt), .wdata_i(wdata_i),
    .cnt_o(cnt_q), .wrap_o(wrap)
  );

  cr_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl_i(wr_en_i & (addr_i == A_CTRL)),
    .wr_mode_i(wr_en_i & (addr_i == A_MODE)),
    .wr_rld_i(wr_rld), .wdata_i(wdata_i),
    .set_ovf_i(set_ovf), .set_evt_i(set_evt),
    .capture_i(capture), .cnt_i(cnt_q),
    .ctrl_o(ctrl_q), .down_en_o(down_en_q), .rld_o(rld_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) baud_q <= 1'b0;
    else        baud_q <= wrap & (mode == M_BAUD);
  end
  assign baud_tick_o = baud_q;

  assign irq_o = ctrl_q.ovf | (ctrl_q.evt & ~down_mode);

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_CTRL:   rd_data_o = ctrl_q;
      A_MODE:   rd_data_o = {{(DW-1){1'b0}}, down_en_q};
      A_CNT_LO: rd_data_o = cnt_q[DW-1:0];
      A_CNT_HI: rd_data_o = cnt_q[2*DW-1:DW];
      A_RLD_LO: rd_data_o = rld_q[DW-1:0];
      A_RLD_HI: rd_data_o = rld_q[2*DW-1:DW];
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/cr_timer_chk.sv
module cr_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic             baud_tick_o,
  input logic [7:0]       ctrl_i,
  input logic             down_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] rld_i,
  input logic             ext_fall_i
);
  logic baud, down_mode;
  assign baud      = ctrl_i[4] | ctrl_i[5];
  assign down_mode = down_en_i & ~ctrl_i[2] & ~baud;

  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> $stable(cnt_i));

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[0] && !wr_en_i && !ext_fall_i) |=> $stable(cnt_i));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[7] && !(wr_en_i && addr_i == 3'd0)) |=> ctrl_i[7]);

  assert_down_no_evt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (down_mode && !ctrl_i[6] && !wr_en_i) |=> !ctrl_i[6]);

  assert_baud_no_ovf_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctrl_i[7] && !wr_en_i) |=> !ctrl_i[7]);

  assert_baud_reloaded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick_o && $past(!wr_en_i)) |-> (cnt_i == rld_i));
endmodule

bind cr_timer cr_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .baud_tick_o(baud_tick_o), .ctrl_i(ctrl_q),
  .down_en_i(down_en_q), .cnt_i(cnt_q), .rld_i(rld_q),
  .ext_fall_i(ext_fall)
);

// File: tb/test_cr_timer.sv
module test_cr_timer;
  logic clk = 0, rst_n = 0, tick = 0, cpin = 0, epin = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic baud, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cr_timer i_cr_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_pin_i(cpin),
    .ext_pin_i(epin), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rd_data_o(rdata), .baud_tick_o(baud), .irq_o(irq)
  );

  task automatic check(string what, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wcnt(logic [15:0] v);
    wreg(3'd2, v[7:0]); wreg(3'd3, v[15:8]);
  endtask

  task automatic wrld(logic [15:0] v);
    wreg(3'd4, v[7:0]); wreg(3'd5, v[15:8]);
  endtask

  task automatic rcnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rreg(3'd2, lo); rreg(3'd3, hi); v = {hi, lo};
  endtask

  task automatic rrld(output logic [15:0] v);
    logic [7:0] lo, hi;
    rreg(3'd4, lo); rreg(3'd5, hi); v = {hi, lo};
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), d); check($sformatf("R1 reset reg %0d", a), 16'(d), 16'h0);
    end
    check("R1 reset irq", 16'(irq), 16'h0);
    check("R1 reset baud", 16'(baud), 16'h0);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    wreg(3'd0, 8'h01);
    ticks(5); rcnt(v); check("R2 timer five ticks", v, 16'd5);
    repeat (6) @(negedge clk);
    rcnt(v); check("R2 no tick no count", v, 16'd5);
    wreg(3'd0, 8'h00);
    ticks(3); rcnt(v); check("R3 stopped holds", v, 16'd5);
  endtask

  task automatic t_counter;
    logic [15:0] v;
    wcnt(16'h0000);
    wreg(3'd0, 8'h03);
    cpin = 1; ticks(1); cpin = 0; ticks(1); ticks(1);
    cpin = 1; ticks(1); cpin = 0; ticks(1);
    rcnt(v); check("R4 two sampled falls", v, 16'd2);
    cpin = 1; repeat (2) @(negedge clk); cpin = 0; repeat (2) @(negedge clk);
    rcnt(v); check("R4 toggle between ticks ignored", v, 16'd2);
  endtask

  task automatic t_capture;
    logic [15:0] v; logic [7:0] c;
    wreg(3'd0, 8'h0C);
    wcnt(16'h1234);
    epin = 1; ticks(1); epin = 0; ticks(1);
    rrld(v); check("R5 captured count", v, 16'h1234);
    rreg(3'd0, c); check("R5 event flag set", 16'(c), 16'h4C);
    check("R6 irq from event flag", 16'(irq), 16'h1);
    wreg(3'd0, 8'h0D);
    wcnt(16'hFFFF);
    ticks(1);
    rcnt(v); check("R6 capture overflow wraps to 0", v, 16'h0000);
    rreg(3'd0, c); check("R6 overflow flag", 16'(c), 16'h8D);
    rrld(v); check("R6 reload untouched", v, 16'h1234);
    wreg(3'd0, 8'h00);
    rreg(3'd0, c); check("R9 flags cleared by write", 16'(c), 16'h00);
    check("R9 irq low after clear", 16'(irq), 16'h0);
  endtask

  task automatic t_reload;
    logic [15:0] v; logic [7:0] c;
    wrld(16'hFFF0);
    wcnt(16'hFFFE);
    wreg(3'd0, 8'h09);
    ticks(1); rcnt(v); check("R7 count to FFFF", v, 16'hFFFF);
    ticks(1); rcnt(v); check("R7 overflow reloads", v, 16'hFFF0);
    rreg(3'd0, c); check("R7 overflow flag", 16'(c), 16'h89);
    ticks(2); rreg(3'd0, c); check("R9 flag stays set", 16'(c), 16'h89);
    wreg(3'd0, 8'h08);
    wcnt(16'h0005);
    epin = 1; ticks(1); epin = 0; ticks(1);
    rcnt(v); check("R8 event reload", v, 16'hFFF0);
    rreg(3'd0, c); check("R8 event flag", 16'(c), 16'h48);
  endtask

  task automatic t_down;
    logic [15:0] v; logic [7:0] c;
    wreg(3'd0, 8'h09);
    wreg(3'd1, 8'h01);
    wrld(16'h0010);
    wcnt(16'h0012);
    epin = 0;
    ticks(1); rcnt(v); check("R10 down step", v, 16'h0011);
    ticks(1); rcnt(v); check("R10 down to reload value", v, 16'h0010);
    ticks(1); rcnt(v); check("R10 underflow to FFFF", v, 16'hFFFF);
    rreg(3'd0, c); check("R10 underflow flag", 16'(c), 16'h89);
    epin = 1; ticks(1); rcnt(v); check("R10 up overflow reloads", v, 16'h0010);
    epin = 0; ticks(1); rcnt(v); check("R11 falling edge no reload", v, 16'hFFFF);
    rreg(3'd0, c); check("R11 no event flag", 16'(c), 16'h89);
    wreg(3'd0, 8'h48);
    check("R11 event flag masked from irq", 16'(irq), 16'h0);
    wreg(3'd1, 8'h00);
    check("R11 irq once down mode left", 16'(irq), 16'h1);
    wreg(3'd0, 8'h00);
  endtask

  task automatic t_baud;
    logic [15:0] v; logic [7:0] c;
    wrld(16'hFFFD);
    wcnt(16'hFFFE);
    wreg(3'd0, 8'h15);
    ticks(1); check("R12 no pulse before overflow", 16'(baud), 16'h0);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check("R12 baud pulse", 16'(baud), 16'h1);
    rcnt(v); check("R12 reload with pulse", v, 16'hFFFD);
    @(negedge clk);
    check("R12 pulse one clock", 16'(baud), 16'h0);
    rreg(3'd0, c); check("R12 no overflow flag", 16'(c), 16'h15);
    wreg(3'd0, 8'h25);
    wcnt(16'hFFFF);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check("R12 receive-clock pulse", 16'(baud), 16'h1);
    rcnt(v); check("R12 receive-clock reload", v, 16'hFFFD);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_counter();
    t_capture();
    t_reload();
    t_down();
    t_baud();
    finish_up();
  end
endmodule